// File: doc/BRIEF.md
# Multiply/Divide Occupancy Tracker

This block follows the timing of a multiply/divide unit without doing any arithmetic. It sees the issue strobes for 32-bit and 64-bit multiplies, 32-bit and 64-bit divides, and writes into the hi and lo result registers. From them it works out when each class may issue again, when the non-pipelined divider is occupied, and when hi and lo may be read. An issue stage uses the flags to hold back an operation that would collide. A strobe is accepted only when its own flag is high in that cycle. At most one operation is accepted per cycle.

A divide holds the shared divider only from the fourth cycle after issue. The divider stays held for 32 or 64 cycles. A following divide can therefore issue while the previous one is still in its final cycles, and the two busy windows meet without a gap.

Hi and lo each have their own ready time, which depends on the operation that last wrote them. Every flag is a register. A flag changes in the cycle after the clock edge at which an operation is accepted.

Top module: `mdo_tracker`

## Requirements
- R1: During and right after a synchronous active-high reset, `can_mul`, `can_div`, `hi_rdy` and `lo_rdy` are 1 and `div_busy` is 0.
- R2: A 32-bit multiply accepted at edge e drops `hi_rdy` and `lo_rdy`. Both return to 1 for a read that issues at edge e+3.
- R3: A 64-bit multiply accepted at edge e makes `lo_rdy` readable at e+3 and `hi_rdy` at e+4. `can_mul` is 0 only for edge e+1.
- R4: A write to hi (or lo) accepted at edge e makes that register readable at e+3. `can_mul` and `can_div` stay 0 until edge e+4. A write to a register whose ready flag is 0 is refused.
- R5: A divide accepted at edge e holds `div_busy` at 1 for edges e+4 through e+3+N. N is 32 for the 32-bit divide and 64 for the 64-bit divide.
- R6: After a divide accepted at edge e, a new divide is refused before edge e+N and accepted from edge e+N. `div_busy` stays 1 across the point where the two busy windows meet.
- R7: After a divide accepted at edge e, hi and lo become readable at edge e+N+8. Until that edge, multiplies and hi/lo writes are refused.
- R8: When several strobes are high at once, only the highest-ranked one that its flag allows is accepted. The order is 64-bit divide, 32-bit divide, 64-bit multiply, 32-bit multiply, hi write, lo write.
- R9: A refused strobe changes no flag and no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_mul32 | input | 1 | Issue strobe, 32-bit multiply |
| iss_mul64 | input | 1 | Issue strobe, 64-bit multiply |
| iss_div32 | input | 1 | Issue strobe, 32-bit divide |
| iss_div64 | input | 1 | Issue strobe, 64-bit divide |
| iss_wr_hi | input | 1 | Issue strobe, move into hi |
| iss_wr_lo | input | 1 | Issue strobe, move into lo |
| can_mul | output | 1 | A multiply may issue this cycle |
| can_div | output | 1 | A divide may issue this cycle |
| div_busy | output | 1 | Divider is held this cycle |
| hi_rdy | output | 1 | hi may be read, or written, this cycle |
| lo_rdy | output | 1 | lo may be read, or written, this cycle |

## Verification
The hardest case is the seam between two back-to-back divides. The second divide must arrive in exactly the first cycle that `can_div` allows. The first divide's busy window must also still be open while the second one sits in its idle lead-in. The stimulus produces this by offering a divide strobe in every cycle after a divide, so acceptance lands on the earliest legal edge. This is done for both widths, and for a 32-bit divide followed by a 64-bit one. A behavioural model keeps absolute edge numbers for every ready time and for the last two busy windows, and it checks all five flags on every cycle through the seam.

// File: rtl/mdo_pkg.sv
package mdo_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_MUL32 = 3'd1,
    OP_MUL64 = 3'd2,
    OP_WR_HI = 3'd3,
    OP_WR_LO = 3'd4,
    OP_DIV32 = 3'd5,
    OP_DIV64 = 3'd6
  } mdo_op_e;
endpackage

// File: rtl/mdo_timer.sv
// Countdown to a ready point: loading V makes idle_q rise V+1 edges later.
module mdo_timer #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         idle_q
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = load ? val : ((cnt_q != '0) ? cnt_q - 1'b1 : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      idle_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      idle_q <= (cnt_d == '0);
    end
  end
endmodule

// File: rtl/mdo_div_occ.sv
// Divider occupancy: idle lead-in of GAP cycles, then a busy window of the
// divide's length; a tail counter keeps the old window alive when a new
// divide is loaded during its last cycles.
module mdo_div_occ #(
  parameter int GAP    = 3,
  parameter int BUSY32 = 32,
  parameter int BUSY64 = 64,
  parameter int W      = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic is64,
  output logic can_q,
  output logic busy_q
);
  localparam logic [W-1:0] LD32 = W'(GAP + BUSY32);
  localparam logic [W-1:0] LD64 = W'(GAP + BUSY64);
  localparam logic [W-1:0] REOK = W'(GAP + 1);

  logic [W-1:0] cnt_q, cnt_d, tail_q, tail_d, lim;
  logic         w64_q, w64_d;

  always_comb begin
    if (load) begin
      cnt_d  = is64 ? LD64 : LD32;
      tail_d = (cnt_q > W'(1)) ? cnt_q - 1'b1 : '0;
      w64_d  = is64;
    end else begin
      cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
      tail_d = (tail_q != '0) ? tail_q - 1'b1 : '0;
      w64_d  = w64_q;
    end
    lim = w64_d ? W'(BUSY64) : W'(BUSY32);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tail_q <= '0;
      w64_q  <= 1'b0;
      can_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tail_q <= tail_d;
      w64_q  <= w64_d;
      can_q  <= (cnt_d <= REOK);
      busy_q <= ((cnt_d != '0) && (cnt_d <= lim)) || (tail_d != '0);
    end
  end
endmodule

// File: rtl/mdo_arbiter.sv
// Picks at most one accepted operation per cycle, in fixed rank order.
module mdo_arbiter
  import mdo_pkg::*;
(
  input  logic    iss_mul32,
  input  logic    iss_mul64,
  input  logic    iss_div32,
  input  logic    iss_div64,
  input  logic    iss_wr_hi,
  input  logic    iss_wr_lo,
  input  logic    can_mul,
  input  logic    can_div,
  input  logic    hi_rdy,
  input  logic    lo_rdy,
  output mdo_op_e op
);
  always_comb begin
    if (iss_div64 && can_div)      op = OP_DIV64;
    else if (iss_div32 && can_div) op = OP_DIV32;
    else if (iss_mul64 && can_mul) op = OP_MUL64;
    else if (iss_mul32 && can_mul) op = OP_MUL32;
    else if (iss_wr_hi && hi_rdy)  op = OP_WR_HI;
    else if (iss_wr_lo && lo_rdy)  op = OP_WR_LO;
    else                           op = OP_NONE;
  end
endmodule

// File: rtl/mdo_tracker.sv
module mdo_tracker
  import mdo_pkg::*;
#(
  parameter int MUL_LAT    = 3,
  parameter int MUL64_HI   = 4,
  parameter int MUL64_HOLD = 1,
  parameter int WR_RD_LAT  = 3,
  parameter int WR_MD_LAT  = 4,
  parameter int DIV_GAP    = 3,
  parameter int DIV32_BUSY = 32,
  parameter int DIV64_BUSY = 64,
  parameter int HILO_WB    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic iss_mul32,
  input  logic iss_mul64,
  input  logic iss_div32,
  input  logic iss_div64,
  input  logic iss_wr_hi,
  input  logic iss_wr_lo,
  output logic can_mul,
  output logic can_div,
  output logic div_busy,
  output logic hi_rdy,
  output logic lo_rdy
);
  localparam int W = $clog2(DIV_GAP + DIV64_BUSY + HILO_WB + 1);
  localparam logic [W-1:0] V_MUL   = W'(MUL_LAT - 1);
  localparam logic [W-1:0] V_M64HI = W'(MUL64_HI - 1);
  localparam logic [W-1:0] V_HOLD  = W'(MUL64_HOLD);
  localparam logic [W-1:0] V_WRRD  = W'(WR_RD_LAT - 1);
  localparam logic [W-1:0] V_WRMD  = W'(WR_MD_LAT - 1);
  localparam logic [W-1:0] V_D32   = W'(DIV_GAP + DIV32_BUSY + HILO_WB);
  localparam logic [W-1:0] V_D64   = W'(DIV_GAP + DIV64_BUSY + HILO_WB);

  mdo_op_e      op;
  logic         is_div, is_mul;
  logic [W-1:0] div_v, hi_v, lo_v;
  logic         hold_idle, md_idle, wb_idle;

  mdo_arbiter u_arb (
    .iss_mul32(iss_mul32), .iss_mul64(iss_mul64),
    .iss_div32(iss_div32), .iss_div64(iss_div64),
    .iss_wr_hi(iss_wr_hi), .iss_wr_lo(iss_wr_lo),
    .can_mul(can_mul), .can_div(can_div),
    .hi_rdy(hi_rdy), .lo_rdy(lo_rdy), .op(op)
  );

  always_comb begin
    is_div = (op == OP_DIV32) || (op == OP_DIV64);
    is_mul = (op == OP_MUL32) || (op == OP_MUL64);
    div_v  = (op == OP_DIV64) ? V_D64 : V_D32;
    case (op)
      OP_MUL64: hi_v = V_M64HI;
      OP_WR_HI: hi_v = V_WRRD;
      OP_DIV32, OP_DIV64: hi_v = div_v;
      default:  hi_v = V_MUL;
    endcase
    case (op)
      OP_WR_LO: lo_v = V_WRRD;
      OP_DIV32, OP_DIV64: lo_v = div_v;
      default:  lo_v = V_MUL;
    endcase
  end

  mdo_timer #(.W(W)) u_hi (.clk(clk), .rst(rst),
    .load(is_div || is_mul || (op == OP_WR_HI)), .val(hi_v), .idle_q(hi_rdy));
  mdo_timer #(.W(W)) u_lo (.clk(clk), .rst(rst),
    .load(is_div || is_mul || (op == OP_WR_LO)), .val(lo_v), .idle_q(lo_rdy));
  mdo_timer #(.W(W)) u_hold (.clk(clk), .rst(rst),
    .load(op == OP_MUL64), .val(V_HOLD), .idle_q(hold_idle));
  mdo_timer #(.W(W)) u_md (.clk(clk), .rst(rst),
    .load((op == OP_WR_HI) || (op == OP_WR_LO)), .val(V_WRMD), .idle_q(md_idle));
  mdo_timer #(.W(W)) u_wb (.clk(clk), .rst(rst),
    .load(is_div), .val(div_v), .idle_q(wb_idle));

  logic occ_can;
  mdo_div_occ #(.GAP(DIV_GAP), .BUSY32(DIV32_BUSY), .BUSY64(DIV64_BUSY), .W(W)) u_div (
    .clk(clk), .rst(rst), .load(is_div), .is64(op == OP_DIV64),
    .can_q(occ_can), .busy_q(div_busy)
  );

  always_comb begin
    can_mul = hold_idle && md_idle && wb_idle;
    can_div = occ_can && md_idle;
  end
endmodule

// File: rtl/mdo_tracker_chk.sv
module mdo_tracker_chk (
  input logic clk,
  input logic rst,
  input logic iss_mul32,
  input logic iss_mul64,
  input logic iss_div32,
  input logic iss_div64,
  input logic iss_wr_hi,
  input logic iss_wr_lo,
  input logic can_mul,
  input logic can_div,
  input logic div_busy,
  input logic hi_rdy,
  input logic lo_rdy
);
  logic div_acc, mul_acc;
  assign div_acc = (iss_div32 || iss_div64) && can_div;
  assign mul_acc = (iss_mul32 || iss_mul64) && can_mul;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (can_mul && can_div && hi_rdy && lo_rdy && !div_busy));

  assert_mul_result_R2: assert property (@(posedge clk) disable iff (rst)
    mul_acc |=> (!hi_rdy && !lo_rdy));

  assert_mul64_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (iss_mul64 && can_mul) |=> !can_mul);

  assert_write_fence_R4: assert property (@(posedge clk) disable iff (rst)
    (iss_wr_hi && hi_rdy && !div_acc && !mul_acc) |=> (!can_mul && !can_div));

  assert_div_reissue_R6: assert property (@(posedge clk) disable iff (rst)
    div_acc |=> !can_div);

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> (!can_mul && !hi_rdy && !lo_rdy));
endmodule

bind mdo_tracker mdo_tracker_chk chk_i (
  .clk(clk), .rst(rst),
  .iss_mul32(iss_mul32), .iss_mul64(iss_mul64),
  .iss_div32(iss_div32), .iss_div64(iss_div64),
  .iss_wr_hi(iss_wr_hi), .iss_wr_lo(iss_wr_lo),
  .can_mul(can_mul), .can_div(can_div), .div_busy(div_busy),
  .hi_rdy(hi_rdy), .lo_rdy(lo_rdy)
);

// File: tb/mdo_tracker_tb_top.sv
`timescale 1ns/1ps
module mdo_tracker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_mul32 = 0, iss_mul64 = 0, iss_div32 = 0, iss_div64 = 0;
  logic iss_wr_hi = 0, iss_wr_lo = 0;
  logic can_mul, can_div, div_busy, hi_rdy, lo_rdy;

  always #2.5 clk = ~clk;

  mdo_tracker dut_i (
    .clk(clk), .rst(rst),
    .iss_mul32(iss_mul32), .iss_mul64(iss_mul64),
    .iss_div32(iss_div32), .iss_div64(iss_div64),
    .iss_wr_hi(iss_wr_hi), .iss_wr_lo(iss_wr_lo),
    .can_mul(can_mul), .can_div(can_div), .div_busy(div_busy),
    .hi_rdy(hi_rdy), .lo_rdy(lo_rdy)
  );

  int checks = 0;
  int errs   = 0;
  string cur = "R1";

  // Reference model: absolute edge numbers at which each resource frees up.
  int n = 0;
  int hi_at = 0, lo_at = 0, md_at = 0, hold_at = 0, wb_at = 0, dok_at = 0;
  int ws0 = -100, we0 = -100, ws1 = -100, we1 = -100;

  task automatic chk(input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%b expected=%b at edge %0d", cur, what, got, exp, n + 1);
    end
  endtask

  task automatic step(input bit m32, input bit m64, input bit d32, input bit d64,
                      input bit whi, input bit wlo);
    int  ep;
    bit  e_mul, e_div, e_busy, e_hi, e_lo;
    iss_mul32 = m32; iss_mul64 = m64; iss_div32 = d32; iss_div64 = d64;
    iss_wr_hi = whi; iss_wr_lo = wlo;
    ep     = n + 1;
    e_mul  = (ep >= hold_at) && (ep >= md_at) && (ep >= wb_at);
    e_div  = (ep >= dok_at) && (ep >= md_at);
    e_busy = ((ep >= ws0) && (ep <= we0)) || ((ep >= ws1) && (ep <= we1));
    e_hi   = (ep >= hi_at);
    e_lo   = (ep >= lo_at);
    #0.5;
    chk("can_mul", can_mul, e_mul);
    chk("can_div", can_div, e_div);
    chk("div_busy", div_busy, e_busy);
    chk("hi_rdy", hi_rdy, e_hi);
    chk("lo_rdy", lo_rdy, e_lo);
    // R8 ranking; R9 refused strobes leave the model untouched
    if ((d64 || d32) && e_div) begin
      int len = d64 ? 64 : 32;
      dok_at = ep + len;
      ws0 = ws1; we0 = we1;
      ws1 = ep + 4; we1 = ep + 3 + len;
      hi_at = ep + len + 8; lo_at = hi_at; wb_at = hi_at;
    end else if (m64 && e_mul) begin
      lo_at = ep + 3; hi_at = ep + 4; hold_at = ep + 2;
    end else if (m32 && e_mul) begin
      lo_at = ep + 3; hi_at = ep + 3;
    end else if (whi && e_hi) begin
      hi_at = ep + 3; md_at = ep + 4;
    end else if (wlo && e_lo) begin
      lo_at = ep + 3; md_at = ep + 4;
    end
    @(posedge clk);
    n++;
    @(negedge clk);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run;
    iss_mul32 = 0; iss_mul64 = 0; iss_div32 = 0; iss_div64 = 0;
    iss_wr_hi = 0; iss_wr_lo = 0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++;
    errs++;
    $display("FAIL watchdog expired during %s", cur);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values while reset is still asserted
    cur = "R1";
    chk("can_mul", can_mul, 1'b1);
    chk("can_div", can_div, 1'b1);
    chk("div_busy", div_busy, 1'b0);
    chk("hi_rdy", hi_rdy, 1'b1);
    chk("lo_rdy", lo_rdy, 1'b1);
    rst = 1'b0;
    idle(2);

    // R2: 32-bit multiply, hi/lo back after 3 edges
    cur = "R2";
    step(1, 0, 0, 0, 0, 0); idle(5);
    step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0); idle(5);

    // R3: 64-bit multiply splits lo/hi and holds off the next multiply one cycle
    cur = "R3";
    step(0, 1, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0); idle(6);
    step(0, 1, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0); idle(6);

    // R4: writes into hi/lo, fence on multiply/divide, refusal while not ready
    cur = "R4";
    step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 0);
    step(1, 0, 1, 0, 0, 0); step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0); idle(6);
    step(0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 1, 0); idle(6);

    // R5, R6: 32-bit divide, retried every cycle until re-accepted at the seam
    cur = "R5";
    step(0, 0, 1, 0, 0, 0);
    cur = "R6";
    for (int i = 0; i < 40; i++) step(0, 0, 1, 0, 0, 0);
    // R7: multiplies and writes refused while the divide result is pending
    cur = "R7";
    for (int i = 0; i < 50; i++) step(i[0], 0, 0, 0, i[1], i[2]);
    idle(10);

    // R5, R6: 64-bit after 32-bit, then back-to-back 64-bit
    cur = "R6";
    step(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 70; i++) step(0, 0, 0, 1, 0, 0);
    cur = "R5";
    idle(80);

    // R8: simultaneous strobes, only the highest-ranked legal one goes
    cur = "R8";
    step(1, 1, 1, 1, 1, 1); idle(80);
    step(1, 1, 0, 0, 1, 1); idle(6);
    step(0, 0, 0, 0, 1, 1); idle(6);
    step(1, 0, 0, 0, 1, 1); idle(6);

    // R9: mixed random traffic, refusals must never disturb timing
    cur = "R9";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 63);
      step(r == 1 || r == 9, r == 2 || r == 9, r == 3, r == 4, r == 5 || r == 7, r == 6 || r == 7);
    end
    idle(80);
    finish_run();
  end
endmodule